// File: doc/BRIEF.md
# Banked Register-File Address Mapper

This block turns an 8-bit register-file operand into a physical location inside a data memory made of three kinds of space: a small set of unbanked core locations, a window of peripheral registers that is repeated once per peripheral bank, and a general-purpose RAM window that is repeated once per RAM bank. A single bank control register holds two independent fields. One steers the peripheral window and the other steers the RAM window. An address that lies outside both windows lands in the same place whatever the bank fields hold.

An operand can be given in four ways. It can be a full 8-bit direct address, or a 5-bit restricted operand that reaches only the low 32 locations. It can also be the contents of either of two pointer registers. All four ways resolve to one effective address and are then decoded identically. Each bank field can be loaded by its own bank-load command from a small immediate, or both can be loaded by an ordinary register write to the bank control register. The RAM banks and the ordinary unbanked cells are held as inferred storage inside the block. Peripheral registers live outside, and the block reaches them through a select, index, bank and write-strobe port.

Reads are combinational from operand to `rdata`. Writes and bank loads take effect on the rising clock edge.

Top module: `regfile_bank_mapper`

## Requirements
- R1: Asynchronous active-low reset clears the bank control register and both pointer registers to 0x00.
- R2: The bank control register sits at address 0x0F. Bits [3:0] form the peripheral bank field and bits [7:4] form the RAM bank field. A write there with `wr_en` high loads both fields from `wdata` at the next rising edge, and a read returns the whole register.
- R3: `bank_ld_peri` loads `bank_imm` into the peripheral field and `bank_ld_ram` loads `bank_imm` into the RAM field, each at the next rising edge. The other field is left unchanged.
- R4: When a bank-load command and a register write to 0x0F occur in the same cycle, the field named by the command takes `bank_imm`. A field that no command names takes the written data.
- R5: Addresses 0x20–0xFF reach RAM bank (RAM field mod 2). Field values 2 and 3 therefore alias banks 0 and 1.
- R6: Addresses 0x00–0x0F and 0x18–0x1F are unbanked and ignore both bank fields. Apart from 0x01, 0x09 and 0x0F, they act as ordinary storage with `per_sel` low.
- R7: Addresses 0x10–0x17 raise `per_sel`. In that case `per_idx` is address[2:0], `per_bank` is the peripheral field, `rdata` equals `per_rdata`, and `per_we` follows `wr_en`. Outside this window both `per_sel` and `per_we` are low.
- R8: `acc_mode` 2'b01 selects the restricted operand. Only `op_addr[4:0]` is used, and it maps exactly as the direct address {3'b000, op_addr[4:0]} would.
- R9: `acc_mode` 2'b10 and 2'b11 use the pointer registers at 0x01 and 0x09 as the effective address, with the same window and bank decoding as direct access (`acc_mode` 2'b00).
- R10: Storage cells are not cleared by reset and keep their contents across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_mode | input | 2 | 00 direct, 01 restricted, 10 pointer 0, 11 pointer 1 |
| op_addr | input | 8 | Operand address |
| wr_en | input | 1 | Write the resolved location |
| wdata | input | 8 | Write data |
| bank_ld_peri | input | 1 | Load peripheral bank field from bank_imm |
| bank_ld_ram | input | 1 | Load RAM bank field from bank_imm |
| bank_imm | input | 4 | Bank-load immediate |
| rdata | output | 8 | Read data of the resolved location |
| per_sel | output | 1 | Peripheral window selected |
| per_we | output | 1 | Peripheral write strobe |
| per_bank | output | 4 | Peripheral bank in use |
| per_idx | output | 3 | Register index inside the peripheral window |
| per_wdata | output | 8 | Data for peripheral writes |
| per_rdata | input | 8 | Read data returned by the peripheral bank |

## Verification
The bench builds the block with its default parameters: two RAM banks behind a four-bit RAM field, an eight-entry peripheral window at 0x10, and a five-bit restricted operand. With two banks the field values 2 and 3 can be reached, so the aliasing path is exercised against data written under fields 0 and 1. Because the peripheral window lies inside the 32-location restricted range, the same register can be reached through direct, restricted and pointer access, and the bench compares all three.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   typedef enum logic [1:0] {
      AM_DIRECT = 2'b00,
      AM_LOWOP  = 2'b01,
      AM_PTR0   = 2'b10,
      AM_PTR1   = 2'b11
   } acc_mode_e;

   typedef enum logic [2:0] {
      RG_CTL,
      RG_PTR0,
      RG_PTR1,
      RG_FLAT,
      RG_PERI,
      RG_RAM
   } region_e;
endpackage

// File: rtl/rbm_addr_sel.sv
module rbm_addr_sel #(
   parameter int AW       = 8,
   parameter int LOWOP_W  = 5
) (
   input  logic [1:0]    mode,
   input  logic [AW-1:0] op_addr,
   input  logic [AW-1:0] ptr0,
   input  logic [AW-1:0] ptr1,
   output logic [AW-1:0] eff_addr
);
   import rbm_pkg::*;

   acc_mode_e m;
   assign m = acc_mode_e'(mode);

   always_comb begin
      unique case (m)
         AM_DIRECT: eff_addr = op_addr;
         AM_LOWOP:  eff_addr = AW'(op_addr[LOWOP_W-1:0]);
         AM_PTR0:   eff_addr = ptr0;
         default:   eff_addr = ptr1;
      endcase
   end
endmodule

// File: rtl/rbm_region_dec.sv
module rbm_region_dec #(
   parameter int AW        = 8,
   parameter int PERI_LO   = 'h10,
   parameter int PERI_HI   = 'h17,
   parameter int RAM_LO    = 'h20,
   parameter int CTL_ADDR  = 'h0F,
   parameter int PTR0_ADDR = 'h01,
   parameter int PTR1_ADDR = 'h09,
   parameter int PIDX_W    = 3,
   parameter int RAM_OW    = 8
) (
   input  logic [AW-1:0]     eff_addr,
   output rbm_pkg::region_e  region,
   output logic [PIDX_W-1:0] peri_idx,
   output logic [RAM_OW-1:0] ram_off
);
   import rbm_pkg::*;

   always_comb begin
      if (eff_addr == AW'(CTL_ADDR))
         region = RG_CTL;
      else if (eff_addr == AW'(PTR0_ADDR))
         region = RG_PTR0;
      else if (eff_addr == AW'(PTR1_ADDR))
         region = RG_PTR1;
      else if (eff_addr >= AW'(PERI_LO) && eff_addr <= AW'(PERI_HI))
         region = RG_PERI;
      else if (eff_addr >= AW'(RAM_LO))
         region = RG_RAM;
      else
         region = RG_FLAT;
   end

   assign peri_idx = PIDX_W'(eff_addr - AW'(PERI_LO));
   assign ram_off  = RAM_OW'(eff_addr - AW'(RAM_LO));
endmodule

// File: rtl/rbm_ctl_regs.sv
module rbm_ctl_regs #(
   parameter int DW  = 8,
   parameter int PBW = 4,
   parameter int RBW = 4,
   parameter int BIW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_ctl,
   input  logic           wr_p0,
   input  logic           wr_p1,
   input  logic [DW-1:0]  wdata,
   input  logic           ld_peri,
   input  logic           ld_ram,
   input  logic [BIW-1:0] bank_imm,
   output logic [DW-1:0]  ctl_q,
   output logic [DW-1:0]  ptr0_q,
   output logic [DW-1:0]  ptr1_q
);
   logic [PBW-1:0] peri_f;
   logic [RBW-1:0] ram_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peri_f <= '0;
         ram_f  <= '0;
         ptr0_q <= '0;
         ptr1_q <= '0;
      end else begin
         if (ld_peri)
            peri_f <= bank_imm[PBW-1:0];
         else if (wr_ctl)
            peri_f <= wdata[PBW-1:0];

         if (ld_ram)
            ram_f <= bank_imm[RBW-1:0];
         else if (wr_ctl)
            ram_f <= wdata[DW-1:PBW];

         if (wr_p0)
            ptr0_q <= wdata;
         if (wr_p1)
            ptr1_q <= wdata;
      end
   end

   assign ctl_q = {ram_f, peri_f};
endmodule

// File: rtl/rbm_store.sv
module rbm_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 224,
   parameter int BANKS = 2,
   parameter int FW    = 4,
   localparam int OW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int BSW  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [FW-1:0] bank_field,
   input  logic [OW-1:0] off,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam bit POW2 = ((BANKS & (BANKS - 1)) == 0);

   logic [BSW-1:0] bsel;
   logic [DW-1:0]  rd_b [BANKS];

   generate
      if (POW2) begin : g_mask
         assign bsel = BSW'(bank_field & FW'(BANKS - 1));
      end else begin : g_mod
         assign bsel = BSW'(bank_field % FW'(BANKS));
      end

      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic [DW-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we && (bsel == BSW'(b)))
               mem[off] <= wdata;
         end
         assign rd_b[b] = mem[off];
      end

      if (BANKS == 1) begin : g_single
         assign rdata = rd_b[0];
      end else begin : g_multi
         assign rdata = rd_b[bsel];
      end
   endgenerate
endmodule

// File: rtl/regfile_bank_mapper.sv
module regfile_bank_mapper #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int PERI_BW   = 4,
   parameter int RAM_BW    = 4,
   parameter int RAM_BANKS = 2,
   parameter int LOWOP_W   = 5,
   parameter int PERI_LO   = 'h10,
   parameter int PERI_HI   = 'h17,
   parameter int RAM_LO    = 'h20,
   parameter int CTL_ADDR  = 'h0F,
   parameter int PTR0_ADDR = 'h01,
   parameter int PTR1_ADDR = 'h09,
   localparam int BIW      = (PERI_BW > RAM_BW) ? PERI_BW : RAM_BW,
   localparam int PIDX_W   = (PERI_HI > PERI_LO) ? $clog2(PERI_HI - PERI_LO + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        acc_mode,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bank_ld_peri,
   input  logic              bank_ld_ram,
   input  logic [BIW-1:0]    bank_imm,
   output logic [DATA_W-1:0] rdata,
   output logic              per_sel,
   output logic              per_we,
   output logic [PERI_BW-1:0] per_bank,
   output logic [PIDX_W-1:0] per_idx,
   output logic [DATA_W-1:0] per_wdata,
   input  logic [DATA_W-1:0] per_rdata
);
   import rbm_pkg::*;

   localparam int RAM_DEPTH  = (1 << ADDR_W) - RAM_LO;
   localparam int RAM_OW     = $clog2(RAM_DEPTH);
   localparam int FLAT_DEPTH = 1 << LOWOP_W;

   generate
      if (PERI_BW + RAM_BW != DATA_W) begin : g_bad_fields
         $error("bank fields must fill the control register");
      end
      if (PERI_HI < PERI_LO || PERI_HI >= RAM_LO) begin : g_bad_peri
         $error("peripheral window must lie below the RAM window");
      end
      if (RAM_LO < FLAT_DEPTH || PERI_HI >= FLAT_DEPTH) begin : g_bad_lowop
         $error("restricted operand range must cover the peripheral window only");
      end
      if (RAM_BANKS < 1 || RAM_BANKS > (1 << RAM_BW)) begin : g_bad_banks
         $error("RAM bank count must be reachable by the RAM field");
      end
      if (CTL_ADDR >= PERI_LO || PTR0_ADDR >= PERI_LO || PTR1_ADDR >= PERI_LO) begin : g_bad_core
         $error("control and pointer registers must be unbanked");
      end
   endgenerate

   logic [ADDR_W-1:0] eff_addr;
   logic [DATA_W-1:0] ctl_q, ptr0_q, ptr1_q;
   logic [DATA_W-1:0] ram_rd, flat_rd;
   logic [RAM_OW-1:0] ram_off;
   logic [PIDX_W-1:0] peri_idx;
   region_e           region;

   rbm_addr_sel #(.AW(ADDR_W), .LOWOP_W(LOWOP_W)) u_sel (
      .mode     (acc_mode),
      .op_addr  (op_addr),
      .ptr0     (ptr0_q),
      .ptr1     (ptr1_q),
      .eff_addr (eff_addr)
   );

   rbm_region_dec #(
      .AW(ADDR_W), .PERI_LO(PERI_LO), .PERI_HI(PERI_HI), .RAM_LO(RAM_LO),
      .CTL_ADDR(CTL_ADDR), .PTR0_ADDR(PTR0_ADDR), .PTR1_ADDR(PTR1_ADDR),
      .PIDX_W(PIDX_W), .RAM_OW(RAM_OW)
   ) u_dec (
      .eff_addr (eff_addr),
      .region   (region),
      .peri_idx (peri_idx),
      .ram_off  (ram_off)
   );

   rbm_ctl_regs #(.DW(DATA_W), .PBW(PERI_BW), .RBW(RAM_BW), .BIW(BIW)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (wr_en && region == RG_CTL),
      .wr_p0    (wr_en && region == RG_PTR0),
      .wr_p1    (wr_en && region == RG_PTR1),
      .wdata    (wdata),
      .ld_peri  (bank_ld_peri),
      .ld_ram   (bank_ld_ram),
      .bank_imm (bank_imm),
      .ctl_q    (ctl_q),
      .ptr0_q   (ptr0_q),
      .ptr1_q   (ptr1_q)
   );

   rbm_store #(.DW(DATA_W), .DEPTH(RAM_DEPTH), .BANKS(RAM_BANKS), .FW(RAM_BW)) u_ram (
      .clk        (clk),
      .we         (wr_en && region == RG_RAM),
      .bank_field (ctl_q[DATA_W-1:PERI_BW]),
      .off        (ram_off),
      .wdata      (wdata),
      .rdata      (ram_rd)
   );

   rbm_store #(.DW(DATA_W), .DEPTH(FLAT_DEPTH), .BANKS(1), .FW(1)) u_flat (
      .clk        (clk),
      .we         (wr_en && region == RG_FLAT),
      .bank_field (1'b0),
      .off        (eff_addr[LOWOP_W-1:0]),
      .wdata      (wdata),
      .rdata      (flat_rd)
   );

   always_comb begin
      unique case (region)
         RG_CTL:  rdata = ctl_q;
         RG_PTR0: rdata = ptr0_q;
         RG_PTR1: rdata = ptr1_q;
         RG_FLAT: rdata = flat_rd;
         RG_PERI: rdata = per_rdata;
         default: rdata = ram_rd;
      endcase
   end

   assign per_sel   = (region == RG_PERI);
   assign per_we    = per_sel && wr_en;
   assign per_idx   = peri_idx;
   assign per_bank  = ctl_q[PERI_BW-1:0];
   assign per_wdata = wdata;
endmodule

// File: rtl/rbm_chk.sv
module rbm_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int PERI_BW  = 4,
   parameter int RAM_BW   = 4,
   parameter int BIW      = 4,
   parameter int PIDX_W   = 3,
   parameter int LOWOP_W  = 5,
   parameter int PERI_LO  = 'h10,
   parameter int PERI_HI  = 'h17,
   parameter int CTL_ADDR = 'h0F
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        acc_mode,
   input logic [ADDR_W-1:0] op_addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic              bank_ld_peri,
   input logic              bank_ld_ram,
   input logic [BIW-1:0]    bank_imm,
   input logic              per_sel,
   input logic              per_we,
   input logic [PIDX_W-1:0] per_idx,
   input logic [DATA_W-1:0] ctl_q
);
   logic in_win, low_in_win;
   assign in_win     = op_addr >= ADDR_W'(PERI_LO) && op_addr <= ADDR_W'(PERI_HI);
   assign low_in_win = ADDR_W'(op_addr[LOWOP_W-1:0]) >= ADDR_W'(PERI_LO)
                    && ADDR_W'(op_addr[LOWOP_W-1:0]) <= ADDR_W'(PERI_HI);

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ctl_q == '0);

   // R2
   ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && acc_mode == 2'b00 && op_addr == ADDR_W'(CTL_ADDR)
       && !bank_ld_peri && !bank_ld_ram) |=> ctl_q == $past(wdata));

   // R3
   peri_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ld_peri |=> ctl_q[PERI_BW-1:0] == $past(bank_imm[PERI_BW-1:0]));

   // R3
   ram_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_ld_ram |=> ctl_q[DATA_W-1:PERI_BW] == $past(bank_imm[RAM_BW-1:0]));

   // R7
   strobe_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_we |-> per_sel);

   // R7
   direct_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mode == 2'b00 && in_win) |-> (per_sel && per_idx == PIDX_W'(op_addr - ADDR_W'(PERI_LO))));

   // R6
   direct_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mode == 2'b00 && !in_win) |-> !per_sel);

   // R8
   lowop_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mode == 2'b01) |-> (per_sel == low_in_win));
endmodule

bind regfile_bank_mapper rbm_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PERI_BW(PERI_BW), .RAM_BW(RAM_BW),
   .BIW(BIW), .PIDX_W(PIDX_W), .LOWOP_W(LOWOP_W), .PERI_LO(PERI_LO),
   .PERI_HI(PERI_HI), .CTL_ADDR(CTL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .op_addr(op_addr),
   .wr_en(wr_en), .wdata(wdata), .bank_ld_peri(bank_ld_peri),
   .bank_ld_ram(bank_ld_ram), .bank_imm(bank_imm), .per_sel(per_sel),
   .per_we(per_we), .per_idx(per_idx), .ctl_q(ctl_q)
);

// File: tb/sim_regfile_bank_mapper.sv
module sim_regfile_bank_mapper;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] acc_mode = 2'b00;
   logic [7:0] op_addr = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       bank_ld_peri = 1'b0;
   logic       bank_ld_ram = 1'b0;
   logic [3:0] bank_imm = 4'h0;
   logic [7:0] rdata;
   logic       per_sel, per_we;
   logic [3:0] per_bank;
   logic [2:0] per_idx;
   logic [7:0] per_wdata;
   logic [7:0] per_rdata = 8'hC3;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef enum int {K_RD, K_SEL, K_BANK, K_IDX, K_WE} kind_e;
   typedef struct {
      kind_e      kind;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sbq[$];

   always #2 clk = ~clk;

   regfile_bank_mapper u0 (
      .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .op_addr(op_addr),
      .wr_en(wr_en), .wdata(wdata), .bank_ld_peri(bank_ld_peri),
      .bank_ld_ram(bank_ld_ram), .bank_imm(bank_imm), .rdata(rdata),
      .per_sel(per_sel), .per_we(per_we), .per_bank(per_bank),
      .per_idx(per_idx), .per_wdata(per_wdata), .per_rdata(per_rdata)
   );

   task automatic drv(input logic [1:0] m, input logic [7:0] a, input logic we,
                      input logic [7:0] d, input logic lp, input logic lr,
                      input logic [3:0] imm);
      @(negedge clk);
      acc_mode = m; op_addr = a; wr_en = we; wdata = d;
      bank_ld_peri = lp; bank_ld_ram = lr; bank_imm = imm;
   endtask

   task automatic rd(input logic [1:0] m, input logic [7:0] a);
      drv(m, a, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0);
   endtask

   task automatic expect_v(input kind_e k, input logic [7:0] v, input string tag);
      item_t it;
      it.kind = k; it.exp = v; it.tag = tag;
      sbq.push_back(it);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #1;
         while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            case (it.kind)
               K_RD:    act = rdata;
               K_SEL:   act = {7'b0, per_sel};
               K_BANK:  act = {4'b0, per_bank};
               K_IDX:   act = {5'b0, per_idx};
               default: act = {7'b0, per_we};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=expired expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h00, "R1 ctl");
      expect_v(K_BANK, 8'h00, "R1 per_bank");
      rd(2'b00, 8'h01); expect_v(K_RD, 8'h00, "R1 ptr0");
      rd(2'b00, 8'h09); expect_v(K_RD, 8'h00, "R1 ptr1");

      // R2: register write to the bank control register
      drv(2'b00, 8'h0F, 1'b1, 8'h13, 1'b0, 1'b0, 4'h0);
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h13, "R2 ctl readback");
      expect_v(K_BANK, 8'h03, "R2 peri field");

      // R3: dedicated loads touch one field only
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h0);
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h03, "R3 ram load");
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 4'h7);
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h07, "R3 peri load");

      // R5: two RAM banks, field modulo 2
      drv(2'b00, 8'h40, 1'b1, 8'hA5, 1'b0, 1'b0, 4'h0);
      drv(2'b00, 8'h20, 1'b1, 8'h22, 1'b0, 1'b0, 4'h0);
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h1);
      drv(2'b00, 8'h40, 1'b1, 8'h5A, 1'b0, 1'b0, 4'h0);
      drv(2'b00, 8'hFF, 1'b1, 8'h3C, 1'b0, 1'b0, 4'h0);
      rd(2'b00, 8'h40); expect_v(K_RD, 8'h5A, "R5 bank1");
      rd(2'b00, 8'hFF); expect_v(K_RD, 8'h3C, "R5 top address bank1");
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h0);
      rd(2'b00, 8'h40); expect_v(K_RD, 8'hA5, "R5 bank0");
      rd(2'b00, 8'h20); expect_v(K_RD, 8'h22, "R5 window base bank0");
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h2);
      rd(2'b00, 8'h40); expect_v(K_RD, 8'hA5, "R5 field2 aliases bank0");
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h3);
      rd(2'b00, 8'h40); expect_v(K_RD, 8'h5A, "R5 field3 aliases bank1");

      // R6: unbanked storage ignores both fields
      drv(2'b00, 8'h18, 1'b1, 8'h77, 1'b0, 1'b0, 4'h0);
      drv(2'b00, 8'h05, 1'b1, 8'h44, 1'b0, 1'b0, 4'h0);
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h0);
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 4'h2);
      rd(2'b00, 8'h18); expect_v(K_RD, 8'h77, "R6 0x18 unbanked");
      expect_v(K_SEL, 8'h00, "R6 no per_sel");
      rd(2'b00, 8'h05); expect_v(K_RD, 8'h44, "R6 0x05 unbanked");
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h1);

      // R7: peripheral window
      rd(2'b00, 8'h12);
      expect_v(K_RD, 8'hC3, "R7 rdata from peripheral");
      expect_v(K_SEL, 8'h01, "R7 per_sel");
      expect_v(K_IDX, 8'h02, "R7 per_idx");
      expect_v(K_BANK, 8'h02, "R7 per_bank");
      drv(2'b00, 8'h17, 1'b1, 8'h99, 1'b0, 1'b0, 4'h0);
      expect_v(K_WE, 8'h01, "R7 per_we");
      expect_v(K_IDX, 8'h07, "R7 top index");
      drv(2'b00, 8'h1A, 1'b1, 8'h31, 1'b0, 1'b0, 4'h0);
      expect_v(K_WE, 8'h00, "R7 no strobe outside");
      rd(2'b00, 8'h10); expect_v(K_WE, 8'h00, "R7 no strobe on read");

      // R8: restricted operand keeps only the low five bits
      rd(2'b01, 8'hF2);
      expect_v(K_SEL, 8'h01, "R8 peri via restricted");
      expect_v(K_IDX, 8'h02, "R8 index via restricted");
      rd(2'b01, 8'hF8); expect_v(K_RD, 8'h77, "R8 0x18 via restricted");
      rd(2'b01, 8'h25); expect_v(K_RD, 8'h44, "R8 0x05 via restricted");
      expect_v(K_SEL, 8'h00, "R8 no per_sel");

      // R9: pointer-based access
      drv(2'b00, 8'h01, 1'b1, 8'h40, 1'b0, 1'b0, 4'h0);
      drv(2'b00, 8'h09, 1'b1, 8'h14, 1'b0, 1'b0, 4'h0);
      rd(2'b10, 8'h00); expect_v(K_RD, 8'h5A, "R9 ptr0 bank1");
      drv(2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 4'h0);
      rd(2'b10, 8'h00); expect_v(K_RD, 8'hA5, "R9 ptr0 bank0");
      rd(2'b11, 8'h00);
      expect_v(K_SEL, 8'h01, "R9 ptr1 per_sel");
      expect_v(K_IDX, 8'h04, "R9 ptr1 per_idx");
      expect_v(K_BANK, 8'h02, "R9 ptr1 per_bank");
      drv(2'b10, 8'h00, 1'b1, 8'h6B, 1'b0, 1'b0, 4'h0);
      rd(2'b00, 8'h40); expect_v(K_RD, 8'h6B, "R9 write via ptr0");

      // R4: same-cycle conflict
      drv(2'b00, 8'h0F, 1'b1, 8'h66, 1'b1, 1'b0, 4'h9);
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h69, "R4 peri load wins");
      drv(2'b00, 8'h0F, 1'b1, 8'h58, 1'b0, 1'b1, 4'h1);
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h18, "R4 ram load wins");

      // R10: storage survives reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(2'b00, 8'h0F); expect_v(K_RD, 8'h00, "R1 ctl after reset");
      rd(2'b00, 8'h01); expect_v(K_RD, 8'h00, "R1 ptr0 after reset");
      rd(2'b00, 8'h40); expect_v(K_RD, 8'h6B, "R10 RAM kept");
      rd(2'b00, 8'h18); expect_v(K_RD, 8'h77, "R10 flat cell kept");

      rd(2'b00, 8'h00);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule